// File: doc/BRIEF.md
# Signed 64-bit Integer to Binary64 Converter

This block takes a raw 64-bit register word, reads it as a two's-complement signed integer, and returns the nearest IEEE-754 binary64 value under a selectable rounding direction. It finds the leading one of the magnitude and shifts the magnitude so that this one becomes the hidden bit. It then rounds the significand to 53 bits, forms the biased exponent and puts the sign, exponent and fraction together into the result word. Beside the result it reports a five-bit result-class code and the per-conversion inexact flags. It also keeps two sticky inexact bits and, when the record-form enable is set, updates a four-bit condition copy of the status summary.

A conversion is started by a one-cycle valid strobe. All results appear together one clock later, along with a one-cycle output-valid pulse. Between conversions the outputs hold their values. The sticky bits stay set until the clear input is pulsed.

Top module: `int_to_dbl_cvt`

## Requirements
- R1: Results are registered one clock after `in_valid` and are marked by a one-cycle `out_valid` pulse. Without a strobe, `out_valid` is 0 and `out_dbl`, `out_class`, `out_fi` and `out_fr` hold their values.
- R2: `in_word` is a signed two's-complement value. A nonzero input gives sign bit `out_dbl[63]` equal to `in_word[63]`. A zero input gives +0.0, which is all 64 bits zero.
- R3: Every input whose magnitude fits in 53 bits converts exactly, with `out_fi`=0 and `out_fr`=0. This covers all values from -2^53 to +2^53.
- R4: `rnd_mode`=2'b00 rounds to nearest, with ties going to the even significand.
- R5: `rnd_mode`=2'b01 truncates toward zero, 2'b10 rounds toward +infinity and 2'b11 rounds toward -infinity.
- R6: `out_fi` is 1 exactly when the conversion discarded nonzero bits. Such a conversion also sets the sticky bits `out_xx` and `out_fx`.
- R7: `out_fr` is 1 only when rounding increased the magnitude of the significand.
- R8: When rounding carries out of the 53-bit significand, the exponent goes up by one and the fraction becomes zero. For example, 2^63-1 rounded to nearest gives 0x43E0000000000000.
- R9: `out_class` is 5'b00100 for a positive normal result, 5'b01000 for a negative normal result and 5'b00010 for +0.0.
- R10: -2^63 converts exactly to sign 1, biased exponent 1086 and fraction 0, which is 0xC3E0000000000000.
- R11: No result is NaN or infinity. The exponent field `out_dbl[62:52]` is never all ones.
- R12: A conversion with `rec_en`=1 loads `out_cr` = {FX, FEX, VX, OX}, using bit 3 for FX. FX is the post-conversion value of `out_fx`, and FEX, VX and OX are 0. A conversion with `rec_en`=0 leaves `out_cr` unchanged.
- R13: `sticky_clr` clears `out_xx` and `out_fx` on the next clock. If an inexact conversion happens in the same cycle, the bits end up set.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Start a conversion this cycle |
| in_word | input | 64 | Raw word read as a signed integer |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| rec_en | input | 1 | Record-form enable for the condition copy |
| sticky_clr | input | 1 | Clear the sticky inexact bits |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_dbl | output | 64 | Binary64 result |
| out_class | output | 5 | Result-class code |
| out_xx | output | 1 | Sticky inexact exception bit |
| out_fx | output | 1 | Sticky exception summary bit |
| out_fi | output | 1 | Last conversion was inexact |
| out_fr | output | 1 | Last conversion rounded the magnitude up |
| out_cr | output | 4 | Condition copy {FX, FEX, VX, OX} |

## Verification
The bench goes after exact ties, one-past-tie values and all-ones inputs, which round up and carry out of the significand. A converter with the tie rule reversed would give odd significands on ties. One that missed the carry would return the fraction as all zeros with the old exponent, which is half the correct value. The bench also covers -2^63, the only input whose magnitude does not fit as a positive value; a sign-magnitude slip there shows up as a wrong sign or a wrong exponent. Finally it runs inputs of exactly 53 and 54 significant bits, where a wrong guard bit position would either raise a false inexact or miss a real one. It also checks the sticky and condition bits across clear and record-form sequences.

// File: rtl/int2d_pkg.sv
package int2d_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rnd_e;

  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;

endpackage

// File: rtl/int2d_lzc.sv
module int2d_lzc #(
  parameter int W    = 64,
  localparam int CW  = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);

  always_comb begin
    cnt      = '0;
    all_zero = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        cnt      = CW'(W - 1 - i);
        all_zero = 1'b0;
      end
    end
  end

endmodule

// File: rtl/int2d_round.sv
module int2d_round
  import int2d_pkg::*;
#(
  parameter int SIG_W = 53
) (
  input  logic [SIG_W-1:0] sig_in,
  input  logic             guard,
  input  logic             sticky,
  input  logic             neg,
  input  logic [1:0]       mode,
  output logic [SIG_W-1:0] sig_out,
  output logic             carry,
  output logic             inexact,
  output logic             up
);

  logic [SIG_W:0] sum;
  rnd_e           rm;

  always_comb begin
    rm      = rnd_e'(mode);
    inexact = guard | sticky;
    unique case (rm)
      RM_NEAR: up = guard & (sticky | sig_in[0]);
      RM_ZERO: up = 1'b0;
      RM_PINF: up = ~neg & inexact;
      RM_NINF: up = neg & inexact;
      default: up = 1'b0;
    endcase
    sum     = {1'b0, sig_in} + {{SIG_W{1'b0}}, up};
    carry   = sum[SIG_W];
    sig_out = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
  end

endmodule

// File: rtl/int2d_status.sv
module int2d_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_valid,
  input  logic       inexact,
  input  logic       rec_en,
  input  logic       clr,
  output logic       xx,
  output logic       fx,
  output logic [3:0] cr
);

  logic       xx_q, xx_n;
  logic       fx_q, fx_n;
  logic [3:0] cr_q, cr_n;
  logic       set_now;

  always_comb begin
    set_now = conv_valid & inexact;
    xx_n    = (clr ? 1'b0 : xx_q) | set_now;
    fx_n    = (clr ? 1'b0 : fx_q) | set_now;
    cr_n    = (conv_valid & rec_en) ? {fx_n, 1'b0, 1'b0, 1'b0} : cr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xx_q <= 1'b0;
      fx_q <= 1'b0;
      cr_q <= 4'h0;
    end else begin
      xx_q <= xx_n;
      fx_q <= fx_n;
      cr_q <= cr_n;
    end
  end

  assign xx = xx_q;
  assign fx = fx_q;
  assign cr = cr_q;

  p_clr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !conv_valid) |=> (!xx && !fx));

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && inexact) |=> (xx && fx));

endmodule

// File: rtl/int_to_dbl_cvt.sv
module int_to_dbl_cvt
  import int2d_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11,
  localparam int SIG_W = FRAC_W + 1,
  localparam int DROP  = INT_W - SIG_W,
  localparam int LZ_W  = $clog2(INT_W),
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int TOP_E = BIAS + INT_W - 1,
  localparam int DW    = 1 + EXP_W + FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [INT_W-1:0] in_word,
  input  logic [1:0]    rnd_mode,
  input  logic          rec_en,
  input  logic          sticky_clr,
  output logic          out_valid,
  output logic [DW-1:0] out_dbl,
  output logic [4:0]    out_class,
  output logic          out_xx,
  output logic          out_fx,
  output logic          out_fi,
  output logic          out_fr,
  output logic [3:0]    out_cr
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // magnitude and normalization
  logic             sgn;
  logic [INT_W-1:0] mag;
  logic [LZ_W-1:0]  lz;
  logic             is_zero;
  logic [INT_W-1:0] norm;

  always_comb begin
    sgn  = in_word[INT_W-1];
    mag  = sgn ? (~in_word + INT_W'(1)) : in_word;
    norm = mag << lz;
  end

  int2d_lzc #(.W(INT_W)) u_lzc (
    .vec      (mag),
    .cnt      (lz),
    .all_zero (is_zero)
  );

  // rounding
  logic [SIG_W-1:0] sig_r;
  logic             rcarry, rinexact, rup;

  int2d_round #(.SIG_W(SIG_W)) u_round (
    .sig_in  (norm[INT_W-1 -: SIG_W]),
    .guard   (norm[DROP-1]),
    .sticky  (|norm[DROP-2:0]),
    .neg     (sgn),
    .mode    (rnd_mode),
    .sig_out (sig_r),
    .carry   (rcarry),
    .inexact (rinexact),
    .up      (rup)
  );

  // result assembly
  logic [EXP_W-1:0] exp_c;
  logic [DW-1:0]    dbl_c;
  logic [4:0]       cls_c;
  logic             fi_c, fr_c;

  always_comb begin
    exp_c = EXP_W'(TOP_E) - EXP_W'(lz) + EXP_W'(rcarry);
    if (is_zero) begin
      dbl_c = '0;
      cls_c = CLS_POS_ZERO;
      fi_c  = 1'b0;
      fr_c  = 1'b0;
    end else begin
      dbl_c = {sgn, exp_c, sig_r[FRAC_W-1:0]};
      cls_c = sgn ? CLS_NEG_NORM : CLS_POS_NORM;
      fi_c  = rinexact;
      fr_c  = rup;
    end
  end

  // output register: next-state and register processes
  logic          vld_q, vld_n;
  logic [DW-1:0] dbl_q, dbl_n;
  logic [4:0]    cls_q, cls_n;
  logic          fi_q, fi_n, fr_q, fr_n;

  always_comb begin
    vld_n = in_valid;
    dbl_n = dbl_q;
    cls_n = cls_q;
    fi_n  = fi_q;
    fr_n  = fr_q;
    if (in_valid) begin
      dbl_n = dbl_c;
      cls_n = cls_c;
      fi_n  = fi_c;
      fr_n  = fr_c;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q <= 1'b0;
      dbl_q <= '0;
      cls_q <= '0;
      fi_q  <= 1'b0;
      fr_q  <= 1'b0;
    end else begin
      vld_q <= vld_n;
      dbl_q <= dbl_n;
      cls_q <= cls_n;
      fi_q  <= fi_n;
      fr_q  <= fr_n;
    end
  end

  int2d_status u_status (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .conv_valid (in_valid),
    .inexact    (fi_c),
    .rec_en     (rec_en),
    .clr        (sticky_clr),
    .xx         (out_xx),
    .fx         (out_fx),
    .cr         (out_cr)
  );

  assign out_valid = vld_q;
  assign out_dbl   = dbl_q;
  assign out_class = cls_q;
  assign out_fi    = fi_q;
  assign out_fr    = fr_q;

  // assertions
  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !in_valid |=> (!out_valid && $stable(out_dbl)));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && in_word == '0) |=> (out_dbl == '0 && out_class == CLS_POS_ZERO));

  p_exact_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && ((&in_word[INT_W-1:SIG_W]) || !(|in_word[INT_W-1:SIG_W])))
      |=> (!out_fi && !out_fr));

  p_trunc_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && rnd_mode == 2'b01) |=> !out_fr);

  p_fr_fi_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && out_fr) |-> out_fi);

  p_class_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && out_dbl[DW-1]) |-> out_class == CLS_NEG_NORM);

  p_finite_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |-> !(&out_dbl[DW-2:FRAC_W]));

  p_rec_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && rec_en) |=> out_cr == {out_fx, 3'b000});

  p_norec_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && !rec_en) |=> $stable(out_cr));

endmodule

// File: tb/sim_int_to_dbl_cvt.sv
`timescale 1ns/1ps
module sim_int_to_dbl_cvt;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, rec_en, sticky_clr;
  logic [63:0] in_word;
  logic [1:0]  rnd_mode;
  logic        out_valid, out_xx, out_fx, out_fi, out_fr;
  logic [63:0] out_dbl;
  logic [4:0]  out_class;
  logic [3:0]  out_cr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic       m_fx;
  logic [3:0] m_cr;

  always #2.5 clk = ~clk;

  int_to_dbl_cvt u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .rnd_mode(rnd_mode), .rec_en(rec_en), .sticky_clr(sticky_clr),
    .out_valid(out_valid), .out_dbl(out_dbl), .out_class(out_class),
    .out_xx(out_xx), .out_fx(out_fx), .out_fi(out_fi), .out_fr(out_fr),
    .out_cr(out_cr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (in=%h mode=%0d)", req, act, exp, in_word, rnd_mode);
    end
  endtask

  // reference built from the requirements: remainder compared with half an ulp
  task automatic ref_conv(input logic [63:0] w, input logic [1:0] md,
                          output logic [63:0] d, output logic inx, output logic up,
                          output logic cy, output logic [4:0] cls);
    logic s;
    logic [63:0] m, q, r, half;
    int bl, sh, e;
    s = w[63];
    m = s ? (~w + 64'd1) : w;
    inx = 0; up = 0; cy = 0;
    if (m == 0) begin
      d = 64'd0; cls = 5'b00010;
    end else begin
      bl = 0;
      for (int i = 0; i < 64; i++) if (m[i]) bl = i + 1;
      e = 1022 + bl;
      if (bl <= 53) begin
        q = m << (53 - bl);
      end else begin
        sh   = bl - 53;
        q    = m >> sh;
        r    = m & ((64'd1 << sh) - 64'd1);
        half = 64'd1 << (sh - 1);
        inx  = (r != 0);
        case (md)
          2'b00: up = (r > half) || (r == half && q[0]);
          2'b01: up = 0;
          2'b10: up = !s && inx;
          default: up = s && inx;
        endcase
        q = q + {63'd0, up};
        if (q == (64'd1 << 53)) begin
          q = q >> 1; e = e + 1; cy = 1;
        end
      end
      d   = {s, 11'(e), q[51:0]};
      cls = s ? 5'b01000 : 5'b00100;
    end
  endtask

  task automatic conv(input logic [63:0] w, input logic [1:0] md, input logic rec,
                      input logic clr);
    logic [63:0] d; logic inx, up, cy; logic [4:0] cls;
    string tag;
    ref_conv(w, md, d, inx, up, cy, cls);
    @(negedge clk);
    in_word = w; rnd_mode = md; rec_en = rec; sticky_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sticky_clr = 1'b0;
    m_fx = (clr ? 1'b0 : m_fx) | inx;
    if (rec) m_cr = {m_fx, 3'b000};
    if (w == 64'h8000_0000_0000_0000) tag = "R10";
    else if (w == 0) tag = "R2";
    else if (cy) tag = "R8";
    else if (!inx) tag = "R3";
    else if (md == 2'b00) tag = "R4";
    else tag = "R5";
    chk("R1 valid", {63'd0, out_valid}, 64'd1);
    chk(tag, out_dbl, d);
    chk("R9 class", {59'd0, out_class}, {59'd0, cls});
    chk("R6 fi", {63'd0, out_fi}, {63'd0, inx});
    chk("R7 fr", {63'd0, out_fr}, {63'd0, up});
    chk("R11 exp", {63'd0, &out_dbl[62:52]}, 64'd0);
    chk("R13 xx", {63'd0, out_xx}, {63'd0, m_fx});
    chk("R6 fx", {63'd0, out_fx}, {63'd0, m_fx});
    chk("R12 cr", {60'd0, out_cr}, {60'd0, m_cr});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, w, lfsr, held;
    rst_n = 1'b0; in_valid = 1'b0; in_word = 64'd0; rnd_mode = 2'b00;
    rec_en = 1'b0; sticky_clr = 1'b0;
    m_fx = 1'b0; m_cr = 4'h0;
    lfsr = 64'hACE1_2468_1357_9BDF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset dbl", out_dbl, 64'd0);
    chk("R13 reset fx", {63'd0, out_fx}, 64'd0);
    chk("R12 reset cr", {60'd0, out_cr}, 64'd0);

    // named corner cases
    conv(64'd0, 2'b00, 1'b1, 1'b0);
    chk("R2 zero", out_dbl, 64'd0);
    conv(64'd1, 2'b00, 1'b0, 1'b0);
    chk("R2 one", out_dbl, 64'h3FF0_0000_0000_0000);
    conv(64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 1'b0);
    chk("R2 minus one", out_dbl, 64'hBFF0_0000_0000_0000);
    conv(64'h8000_0000_0000_0000, 2'b00, 1'b1, 1'b0);
    chk("R10 min int", out_dbl, 64'hC3E0_0000_0000_0000);
    conv(64'd1 << 53, 2'b00, 1'b0, 1'b0);
    chk("R3 2^53 fi", {63'd0, out_fi}, 64'd0);
    conv(-(64'd1 << 53), 2'b00, 1'b0, 1'b0);
    chk("R3 -2^53 fi", {63'd0, out_fi}, 64'd0);
    conv((64'd1 << 53) + 64'd1, 2'b00, 1'b0, 1'b0);
    chk("R4 tie even down", out_dbl, 64'h4340_0000_0000_0000);
    conv((64'd1 << 53) + 64'd3, 2'b00, 1'b0, 1'b0);
    chk("R4 tie even up", out_dbl, 64'h4340_0000_0000_0002);
    conv(64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b0);
    chk("R8 carry", out_dbl, 64'h43E0_0000_0000_0000);
    chk("R12 cr fx", {60'd0, out_cr}, 64'h8);

    // R1 hold without strobe
    held = out_dbl;
    repeat (3) @(negedge clk);
    chk("R1 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R1 hold", out_dbl, held);

    // R13 clear alone, then clear with inexact conversion
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0; m_fx = 1'b0;
    chk("R13 clr xx", {63'd0, out_xx}, 64'd0);
    chk("R13 clr fx", {63'd0, out_fx}, 64'd0);
    chk("R12 cr kept", {60'd0, out_cr}, 64'h8);
    conv(64'd5, 2'b00, 1'b1, 1'b0);
    chk("R12 cr exact", {60'd0, out_cr}, 64'h0);
    conv(64'h7FFF_FFFF_FFFF_FFFF, 2'b01, 1'b0, 1'b1);
    chk("R13 clr+set", {63'd0, out_fx}, 64'd1);
    chk("R12 norec", {60'd0, out_cr}, 64'h0);

    // sweep: every bit length, several patterns, both signs, all modes
    for (int md = 0; md < 4; md++) begin
      for (int bl = 1; bl <= 64; bl++) begin
        for (int p = 0; p < 6; p++) begin
          for (int sg = 0; sg < 2; sg++) begin
            v = 64'd1 << (bl - 1);
            case (p)
              0: ;
              1: v = (bl == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bl) - 64'd1);
              2: v = v | 64'd1;
              3: if (bl >= 54) v = v | (64'd1 << (bl - 54));
              4: begin
                   lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                   v = v | (lfsr & (v - 64'd1));
                 end
              default: if (bl >= 54) v = v | (64'd1 << (bl - 54)) | (64'd1 << (bl - 53));
            endcase
            w = sg[0] ? (~v + 64'd1) : v;
            conv(w, md[1:0], p[0], (p == 5) && sg[0]);
          end
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule